// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single asynchronous serial input line into parallel characters. An external 16x oversampling enable pulse paces it. The receiver confirms a falling edge as a real start bit and samples every later bit at its midpoint. It assembles a character of 5 to 8 bits, least significant bit first, and holds that character in a one-entry buffer until a read strobe collects it.

Static configuration inputs set the word length and the parity mode. A parity bit can be absent, odd, even, forced to 1 or forced to 0. Each completed frame updates five line-status flags: character waiting, overrun, parity mismatch, bad stop bit and break. The four error flags stay set until a status-read strobe clears them. The block is meant to sit behind a FIFO and a register interface that are built elsewhere.

Top module: `serial_frame_rx`

## Requirements
- R1: `wlen` selects the character size: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits arrive LSB first and are placed from `rx_byte[0]` upward. Unused upper bits of `rx_byte` read as 0.
- R2: A low level seen on an oversampling tick is checked again 8 ticks later. If the line is high at that check, the event is dropped as a glitch, the receiver returns to hunting, and no flag or data changes.
- R3: `data_ready` is set when a frame completes and cleared by a one-cycle `data_rd` pulse. If `data_rd` is high in the same cycle that a frame completes, `data_ready` ends set and `rx_byte` holds the new character.
- R4: If a frame completes while `data_ready` is set and `data_rd` is low, `overrun_err` is set and `rx_byte` keeps the older, unread character.
- R5: With `par_en`=0 no parity bit is expected. With `par_en`=1 and `par_stick`=0, `par_even`=1 asks for even parity and `par_even`=0 asks for odd parity. With `par_stick`=1 the parity bit must be 1 when `par_even`=0 and 0 when `par_even`=1. A mismatch sets `parity_err`.
- R6: `frame_err` is set when the first stop bit, sampled at its midpoint, is 0. Only one stop bit is ever checked, so frames that follow each other with a single stop bit are all received.
- R7: A frame whose start, data, parity and stop samples are all 0 sets `break_flag` and `frame_err` and stores 0x00. After any frame with a 0 stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R8: `overrun_err`, `parity_err`, `frame_err` and `break_flag` stay set until a `status_rd` pulse. If an error is raised in the same cycle as `status_rd`, the flag ends set.
- R9: Reset clears all flags and `rx_byte` and returns the receiver to hunting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial input line, idles high |
| wlen | input | 2 | Character size code |
| par_en | input | 1 | A parity bit is present |
| par_even | input | 1 | Even parity, or sense of the forced bit |
| par_stick | input | 1 | Parity bit is forced to a fixed value |
| data_rd | input | 1 | Read strobe, clears data_ready |
| status_rd | input | 1 | Status read strobe, clears the error flags |
| rx_byte | output | 8 | Held character |
| data_ready | output | 1 | A character is waiting |
| overrun_err | output | 1 | A character was lost |
| parity_err | output | 1 | Parity bit mismatch |
| frame_err | output | 1 | First stop bit sampled low |
| break_flag | output | 1 | Whole frame held low |

## Verification
Two functions can land in the same cycle. A frame can complete in the cycle where a read strobe clears the buffer, and an error can be raised in the cycle where a status strobe clears the flags. The bench holds `data_rd` or `status_rd` high throughout a frame and releases it only once the flag is seen set, so the strobe is high in the completion cycle. It then expects the flag to stay set and the new character to be in the buffer with no overrun. Random frames across every size and parity mode are compared against a character and parity model computed in the bench.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       data_rd,
  input  logic       status_rd,
  output logic [7:0] rx_byte,
  output logic       data_ready,
  output logic       overrun_err,
  output logic       parity_err,
  output logic       frame_err,
  output logic       break_flag
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          allz, par_bad;

  wire [2:0] last_idx = {1'b1, wlen};
  wire       data_par = ^shreg;
  wire       exp_par  = par_stick ? ~par_even : (par_even ? data_par : ~data_par);
  wire       at_last  = tick16 && cnt == LAST;
  wire       done     = st == S_STOP && at_last;
  wire       brk      = allz && !rxd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      allz    <= 1'b0;
      par_bad <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rxd) st <= S_START;
        end
        S_START: begin
          if (cnt == MID) begin
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            allz    <= 1'b1;
            par_bad <= 1'b0;
            st      <= rxd ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (cnt == LAST) begin
            cnt         <= '0;
            shreg[bidx] <= rxd;
            allz        <= allz && !rxd;
            if (bidx == last_idx) st <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (cnt == LAST) begin
            cnt     <= '0;
            par_bad <= rxd != exp_par;
            allz    <= allz && !rxd;
            st      <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= rxd ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      data_ready  <= 1'b0;
      overrun_err <= 1'b0;
      parity_err  <= 1'b0;
      frame_err   <= 1'b0;
      break_flag  <= 1'b0;
    end else begin
      if (done && (!data_ready || data_rd)) rx_byte <= shreg;
      data_ready  <= (data_ready && !data_rd) || done;
      overrun_err <= (overrun_err && !status_rd) || (done && data_ready && !data_rd);
      parity_err  <= (parity_err && !status_rd) || (done && par_bad);
      frame_err   <= (frame_err && !status_rd) || (done && !rxd);
      break_flag  <= (break_flag && !status_rd) || (done && brk);
    end
  end

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (rx_byte & ~(8'hFF >> (3 - wlen))) == 8'h00);
  p_tick_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(st));
  p_overrun_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(data_ready));
  p_break_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_flag) |-> frame_err);
  p_parity_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_err) |-> $past(status_rd));
  p_frame_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $past(status_rd));
  p_ready_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(data_rd));
endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  localparam int BITCLK = 48;

  logic       clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
  logic [1:0] wlen = 2'b11;
  logic       par_en = 0, par_even = 0, par_stick = 0, data_rd = 0, status_rd = 0;
  logic [7:0] rx_byte;
  logic       data_ready, overrun_err, parity_err, frame_err, break_flag;
  int         n_chk = 0, n_bad = 0, tcnt = 0;
  bit         ended = 0;

  serial_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .data_rd(data_rd), .status_rd(status_rd), .rx_byte(rx_byte),
    .data_ready(data_ready), .overrun_err(overrun_err), .parity_err(parity_err),
    .frame_err(frame_err), .break_flag(break_flag));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= (tcnt == 2) ? 0 : tcnt + 1;
    tick16 <= (tcnt == 2);
  end

  function automatic logic [7:0] mask_of(input logic [1:0] w);
    return 8'hFF >> (3 - w);
  endfunction

  function automatic logic good_par(input logic [7:0] d, input logic [1:0] w,
                                    input logic ev, input logic st);
    logic ones;
    ones = ^(d & mask_of(w));
    if (st) return ~ev;
    return ev ? ones : ~ones;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    put_bit(1'b0);
    for (int i = 0; i < 5 + wlen; i++) put_bit(d[i]);
    if (par_en) put_bit(good_par(d, wlen, par_even, par_stick) ^ bad_par);
    put_bit(!bad_stop);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic pulse_rd(input bit dr, input bit sr);
    data_rd = dr; status_rd = sr;
    @(negedge clk);
    data_rd = 0; status_rd = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2;
    bit bp;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({data_ready, overrun_err, parity_err, frame_err, break_flag} == 0, "R9 reset flags",
          {data_ready, overrun_err, parity_err, frame_err, break_flag}, 0);
    check(rx_byte == 0, "R9 reset byte", rx_byte, 0);

    // R2 glitch: low for 3 ticks only
    rxd = 0; repeat (9) @(negedge clk); rxd = 1;
    repeat (3 * BITCLK) @(negedge clk);
    check(!data_ready && !frame_err, "R2 glitch ignored", data_ready, 0);

    // R1 random frames across sizes and parity modes (R5)
    for (int k = 0; k < 120; k++) begin
      wlen = 2'($urandom_range(0, 3));
      par_en = 1'($urandom); par_even = 1'($urandom); par_stick = 1'($urandom);
      d  = 8'($urandom);
      bp = ($urandom_range(0, 7) == 0);
      send_frame(d, bp, 0);
      check(data_ready, "R3 ready set", data_ready, 1);
      check(rx_byte == (d & mask_of(wlen)), "R1 byte", rx_byte, d & mask_of(wlen));
      check(parity_err == (bp && par_en), "R5 parity", parity_err, bp && par_en);
      check(!frame_err && !overrun_err, "R6 no frame/overrun", {frame_err, overrun_err}, 0);
      pulse_rd(1, 1);
      check(!data_ready && !parity_err, "R3 R8 cleared", {data_ready, parity_err}, 0);
    end

    // R6 bad stop bit, R8 sticky across data read
    wlen = 2'b11; par_en = 0; par_stick = 0;
    send_frame(8'hA5, 0, 1);
    check(frame_err && !break_flag, "R6 frame err", {frame_err, break_flag}, 2);
    check(rx_byte == 8'hA5, "R6 byte kept", rx_byte, 8'hA5);
    pulse_rd(1, 0);
    check(frame_err, "R8 sticky", frame_err, 1);
    pulse_rd(0, 1);
    check(!frame_err, "R8 cleared", frame_err, 0);

    // R6 back-to-back frames with one stop bit
    send_frame(8'h3C, 0, 0);
    send_frame(8'hC3, 0, 0);
    check(overrun_err && rx_byte == 8'h3C, "R4 overrun keeps old", rx_byte, 8'h3C);
    check(data_ready, "R4 ready stays", data_ready, 1);
    pulse_rd(1, 1);

    // R7 break: whole frame low with parity, then held low a while
    par_en = 1; par_even = 1;
    rxd = 0; repeat (13 * BITCLK) @(negedge clk);
    rxd = 1; repeat (2 * BITCLK) @(negedge clk);
    check(break_flag && frame_err, "R7 break flags", {break_flag, frame_err}, 3);
    check(data_ready && rx_byte == 0, "R7 zero char", rx_byte, 0);
    pulse_rd(1, 1);
    repeat (2 * BITCLK) @(negedge clk);
    check(!data_ready && !break_flag, "R7 no restart while low", {data_ready, break_flag}, 0);

    // R5 stick modes explicit
    par_stick = 1; par_even = 0; wlen = 2'b00;
    rxd = 0; put_bit(0); for (int i = 0; i < 5; i++) put_bit(1); put_bit(0); put_bit(1);
    repeat (24) @(negedge clk);
    check(parity_err, "R5 mark wants 1", parity_err, 1);
    pulse_rd(1, 1);
    par_even = 1;
    rxd = 0; put_bit(0); for (int i = 0; i < 5; i++) put_bit(1); put_bit(0); put_bit(1);
    repeat (24) @(negedge clk);
    check(!parity_err && rx_byte == 8'h1F, "R5 space wants 0", parity_err, 0);
    pulse_rd(1, 1);

    // R3 same-cycle read and completion
    par_en = 0; par_stick = 0; wlen = 2'b11;
    d2 = 8'h96;
    fork
      send_frame(d2, 0, 0);
      begin
        data_rd = 1;
        while (!data_ready) @(negedge clk);
        data_rd = 0;
      end
    join
    check(data_ready && rx_byte == d2, "R3 set wins over read", rx_byte, d2);
    check(!overrun_err, "R4 no overrun on same-cycle read", overrun_err, 0);
    pulse_rd(1, 1);

    // R8 same-cycle status read and parity error
    par_en = 1; par_even = 1;
    fork
      send_frame(8'h11, 1, 0);
      begin
        status_rd = 1;
        while (!parity_err) @(negedge clk);
        status_rd = 0;
      end
    join
    check(parity_err, "R8 set wins over status read", parity_err, 1);
    pulse_rd(1, 1);

    finish_run();
  end
endmodule